// File: doc/BRIEF.md
# Hybrid Logarithmic Neuron MAC

This block is the multiply-accumulate engine of one neuron. The neuron keeps its weights in a local memory, each stored as a sign, a zero flag and a signed fixed-point base-2 logarithm of the magnitude. An input value arrives in the same form together with a weight address. The product is formed by adding the two logarithms and combining the two signs. A cheap piecewise-linear antilog then turns the summed logarithm into a linear magnitude. That magnitude is added to, or subtracted from, a wide saturating linear accumulator. No hardware multiplier is used anywhere.

A sequence starts with a clear pulse. One input beat per cycle can then be presented with `in_valid`. After the last beat has passed through the two pipeline stages, `done` goes high and `acc_out` holds the weighted sum. The weight memory is loaded through its own write port while no sequence is in flight.

Top module: `hyb_log_mac`

## Requirements
- R1: A log word is 10 bits: bit 9 is the sign (1 = negative), bit 8 is the zero flag (1 = the value is zero), and bits 7:0 hold a two's-complement log2 magnitude m with FRAC fraction bits, so the value is ±2^(m/2^FRAC). Inputs and weights share this layout.
- R2: For a product, s = m_data + m_weight, e = floor(s / 2^FRAC) and f = s mod 2^FRAC. The linear magnitude is (2^FRAC + f) shifted left by e, or right by -e with truncation, in accumulator units of 2^-FRAC. If e > ACC_W-2-FRAC the magnitude becomes 2^(ACC_W-1)-1. The product sign is the XOR of the two sign bits.
- R3: The accumulator is ACC_W-bit two's complement. A positive product is added and a negative product is subtracted. The result saturates at 2^(ACC_W-1)-1 and at -2^(ACC_W-1).
- R4: If either operand has its zero flag set, the beat leaves the accumulator unchanged.
- R5: A beat sampled at clock edge k is visible in `acc_out` after edge k+1. Beats may arrive back to back, and each one adds exactly one product.
- R6: After a clock edge with `clear` high, `acc_out` is 0 and `done` is low. A beat still in flight is discarded, and so is a beat presented in the same cycle as `clear`.
- R7: `done` goes high after the edge that accumulates a beat when no new beat is sampled at that edge. It stays high until an edge samples `clear` or a new beat, after which it is low.
- R8: With `w_wr_en` high at an edge, `w_wr_data` is stored at `w_wr_addr`, and beats sampled at later edges use the new weight. A write is allowed only when no beat is presented and none is in flight.
- R9: With no beat in flight and no clear, `acc_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| w_wr_en | input | 1 | Weight memory write enable |
| w_wr_addr | input | 8 | Weight memory write address |
| w_wr_data | input | 10 | Weight word in log form |
| clear | input | 1 | Zero the accumulator and flush the pipeline |
| in_valid | input | 1 | An input beat is present |
| in_data | input | 10 | Input value in log form |
| in_waddr | input | 8 | Weight address paired with the input |
| acc_out | output | 24 | Signed accumulated sum, LSB = 2^-FRAC |
| done | output | 1 | Sequence has drained |

## Verification
The checker assumes that software never writes a weight while a beat is presented or still sits in the product register. The stimulus keeps to this: every weight rewrite comes after at least one idle cycle following the last beat. The other properties also rely on `clear` being the only way the pipeline is emptied early, so that a stable accumulator can be expected whenever the product register is empty or carries a zero-flagged product. Random beats are interleaved with idle gaps, clears and rewrites. Directed runs drive the accumulator into both saturation limits and use shift amounts that push bits off the right-hand end.

// File: rtl/nmac_pkg.sv
package nmac_pkg;

    localparam int WORD_W = 10;
    localparam int MAG_W  = WORD_W - 2;
    localparam int SUM_W  = MAG_W + 1;

    typedef struct packed {
        logic                    neg;
        logic                    zero;
        logic signed [MAG_W-1:0] mag;
    } lword_t;

    typedef struct packed {
        logic                    neg;
        logic                    zero;
        logic signed [SUM_W-1:0] lsum;
    } lprod_t;

    function automatic lprod_t log_mul(lword_t a, lword_t b);
        lprod_t p;
        p.neg  = a.neg ^ b.neg;
        p.zero = a.zero | b.zero;
        p.lsum = SUM_W'(a.mag) + SUM_W'(b.mag);
        return p;
    endfunction

endpackage

// File: rtl/nmac_wmem.sv
module nmac_wmem
    import nmac_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  lword_t        wr_data,
    input  logic [AW-1:0] rd_addr,
    output lword_t        rd_data
);

    lword_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    assign rd_data = store[rd_addr];

endmodule

// File: rtl/nmac_logmul.sv
module nmac_logmul
    import nmac_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   flush,
    input  logic   in_valid,
    input  lword_t data,
    input  lword_t weight,
    output logic   s1_valid,
    output lprod_t s1_prod
);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= in_valid;
        end
        if (rst) begin
            s1_prod <= '0;
        end else if (in_valid) begin
            s1_prod <= log_mul(data, weight);
        end
    end

endmodule

// File: rtl/nmac_accum.sv
module nmac_accum
    import nmac_pkg::*;
#(
    parameter int FRAC  = 4,
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    in_valid,
    input  logic                    s1_valid,
    input  lprod_t                  s1_prod,
    output logic signed [ACC_W-1:0] acc,
    output logic                    done
);

    localparam int MAX_LSH = ACC_W - 2 - FRAC;
    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [SUM_W-1:0] e_part;
    logic [FRAC:0]           mant;
    logic [ACC_W-1:0]        mag;
    logic signed [ACC_W:0]   wide;
    logic signed [ACC_W-1:0] acc_nxt;
    int                      ei;

    // piecewise-linear antilog: 2^(e + f) ~ (1 + f) * 2^e
    always_comb begin
        e_part = s1_prod.lsum >>> FRAC;
        ei     = int'(e_part);
        mant   = {1'b1, s1_prod.lsum[FRAC-1:0]};
        if (ei > MAX_LSH) begin
            mag = ACC_MAX;
        end else if (ei >= 0) begin
            mag = ACC_W'(mant) << ei;
        end else begin
            mag = ACC_W'(mant) >> (-ei);
        end
    end

    // saturating signed add / subtract
    always_comb begin
        if (s1_prod.neg) begin
            wide = {acc[ACC_W-1], acc} - {1'b0, mag};
        end else begin
            wide = {acc[ACC_W-1], acc} + {1'b0, mag};
        end
        if (wide[ACC_W] != wide[ACC_W-1]) begin
            acc_nxt = wide[ACC_W] ? ACC_MIN : ACC_MAX;
        end else begin
            acc_nxt = wide[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc  <= '0;
            done <= 1'b0;
        end else begin
            if (s1_valid && !s1_prod.zero) begin
                acc <= acc_nxt;
            end
            if (in_valid) begin
                done <= 1'b0;
            end else if (s1_valid) begin
                done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/hyb_log_mac.sv
module hyb_log_mac
    import nmac_pkg::*;
#(
    parameter int FRAC  = 4,
    parameter int ACC_W = 24,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    w_wr_en,
    input  logic [AW-1:0]           w_wr_addr,
    input  logic [WORD_W-1:0]       w_wr_data,
    input  logic                    clear,
    input  logic                    in_valid,
    input  logic [WORD_W-1:0]       in_data,
    input  logic [AW-1:0]           in_waddr,
    output logic signed [ACC_W-1:0] acc_out,
    output logic                    done
);

    lword_t weight;
    logic   s1_vld;
    lprod_t s1_prod;

    nmac_wmem #(.DEPTH(DEPTH), .AW(AW)) wmem_i (
        .clk     (clk),
        .wr_en   (w_wr_en),
        .wr_addr (w_wr_addr),
        .wr_data (lword_t'(w_wr_data)),
        .rd_addr (in_waddr),
        .rd_data (weight)
    );

    nmac_logmul logmul_i (
        .clk      (clk),
        .rst      (rst),
        .flush    (clear),
        .in_valid (in_valid && !clear),
        .data     (lword_t'(in_data)),
        .weight   (weight),
        .s1_valid (s1_vld),
        .s1_prod  (s1_prod)
    );

    nmac_accum #(.FRAC(FRAC), .ACC_W(ACC_W)) accum_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .in_valid (in_valid),
        .s1_valid (s1_vld),
        .s1_prod  (s1_prod),
        .acc      (acc_out),
        .done     (done)
    );

endmodule

// File: rtl/hyb_log_mac_chk.sv
module hyb_log_mac_chk #(
    parameter int ACC_W = 24
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    w_wr_en,
    input logic                    clear,
    input logic                    in_valid,
    input logic signed [ACC_W-1:0] acc_out,
    input logic                    done,
    input logic                    s1_vld,
    input logic                    s1_neg,
    input logic                    s1_zero
);

    p_wr_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        w_wr_en |-> (!in_valid && !s1_vld));

    p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
        clear |=> (acc_out == '0 && !done));

    p_beat_lat_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !clear) |=> s1_vld);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!s1_vld && !clear) |=> $stable(acc_out));

    p_zero_skip_r4: assert property (@(posedge clk) disable iff (rst)
        (s1_vld && s1_zero && !clear) |=> $stable(acc_out));

    p_pos_rise_r3: assert property (@(posedge clk) disable iff (rst)
        (s1_vld && !s1_zero && !s1_neg && !clear) |=> (acc_out >= $past(acc_out)));

    p_neg_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (s1_vld && !s1_zero && s1_neg && !clear) |=> (acc_out <= $past(acc_out)));

    p_done_set_r7: assert property (@(posedge clk) disable iff (rst)
        (s1_vld && !in_valid && !clear) |=> done);

    p_done_clr_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> !done);

endmodule

bind hyb_log_mac hyb_log_mac_chk #(.ACC_W(ACC_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .w_wr_en  (w_wr_en),
    .clear    (clear),
    .in_valid (in_valid),
    .acc_out  (acc_out),
    .done     (done),
    .s1_vld   (s1_vld),
    .s1_neg   (s1_prod.neg),
    .s1_zero  (s1_prod.zero)
);

// File: tb/hyb_log_mac_tb_top.sv
module hyb_log_mac_tb_top;

    localparam int FRAC  = 4;
    localparam int ACC_W = 24;
    localparam int DEPTH = 256;
    localparam longint ACC_MAX = (longint'(1) << (ACC_W - 1)) - 1;
    localparam longint ACC_MIN = -(longint'(1) << (ACC_W - 1));

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              w_wr_en = 1'b0;
    logic [7:0]        w_wr_addr = '0;
    logic [9:0]        w_wr_data = '0;
    logic              clear = 1'b0;
    logic              in_valid = 1'b0;
    logic [9:0]        in_data = '0;
    logic [7:0]        in_waddr = '0;
    logic signed [ACC_W-1:0] acc_out;
    logic              done;

    int errors = 0;
    int checks = 0;

    logic [9:0] m_mem [DEPTH];
    logic       m_s1v = 1'b0;
    longint     m_s1p = 0;
    longint     m_acc = 0;
    logic       m_done = 1'b0;

    always #5 clk = ~clk;

    hyb_log_mac #(.FRAC(FRAC), .ACC_W(ACC_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .w_wr_en(w_wr_en), .w_wr_addr(w_wr_addr),
        .w_wr_data(w_wr_data), .clear(clear), .in_valid(in_valid),
        .in_data(in_data), .in_waddr(in_waddr), .acc_out(acc_out), .done(done)
    );

    // product value from the word layout and antilog rule
    function automatic longint prod_lin(logic [9:0] d, logic [9:0] w);
        int s, e, f;
        longint mant, mag;
        if (d[8] || w[8]) return 0;
        s = int'($signed(d[7:0])) + int'($signed(w[7:0]));
        e = s >>> FRAC;
        f = s & ((1 << FRAC) - 1);
        mant = longint'((1 << FRAC) + f);
        if (e > ACC_W - 2 - FRAC) mag = ACC_MAX;
        else if (e >= 0)          mag = mant << e;
        else                      mag = mant >> (-e);
        return (d[9] ^ w[9]) ? -mag : mag;
    endfunction

    function automatic longint sat(longint v);
        if (v > ACC_MAX) return ACC_MAX;
        if (v < ACC_MIN) return ACC_MIN;
        return v;
    endfunction

    task automatic check(string tag);
        checks++;
        if (longint'(acc_out) != m_acc) begin
            errors++;
            $display("FAIL %s acc_out actual=%0d expected=%0d", tag, acc_out, m_acc);
        end
        checks++;
        if (done !== m_done) begin
            errors++;
            $display("FAIL R7 done actual=%0b expected=%0b (%s)", done, m_done, tag);
        end
    endtask

    // one clock: update the model with the sampled inputs, then check
    task automatic cyc(string tag);
        @(posedge clk);
        if (rst || clear) begin
            m_acc = 0; m_done = 1'b0; m_s1v = 1'b0;
        end else begin
            if (m_s1v) m_acc = sat(m_acc + m_s1p);
            if (in_valid) m_done = 1'b0;
            else if (m_s1v) m_done = 1'b1;
            m_s1v = in_valid;
            if (in_valid) m_s1p = prod_lin(in_data, m_mem[in_waddr]);
        end
        if (w_wr_en) m_mem[w_wr_addr] = w_wr_data;
        #1;
        if (!rst) check(tag);
    endtask

    task automatic wr(logic [7:0] a, logic [9:0] d);
        w_wr_en = 1'b1; w_wr_addr = a; w_wr_data = d;
        cyc("R8");
        w_wr_en = 1'b0;
    endtask

    task automatic beat(logic [9:0] d, logic [7:0] a, string tag);
        in_valid = 1'b1; in_data = d; in_waddr = a;
        cyc(tag);
        in_valid = 1'b0;
    endtask

    task automatic clr(string tag);
        clear = 1'b1;
        cyc(tag);
        clear = 1'b0;
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    function automatic logic [9:0] rnd_word();
        logic [9:0] v;
        v = 10'($urandom);
        v[8] = ($urandom % 8 == 0);
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        idle(1, "R6");                       // reset state: acc 0, done low

        // weights: directed corners at 0..3, random elsewhere
        wr(8'd0, 10'h000);                   // +1.0
        wr(8'd1, 10'h07F);                   // largest positive log
        wr(8'd2, 10'h27F);                   // R1 sign bit 9 set
        wr(8'd3, 10'h100);                   // R4 zero flag bit 8 set
        for (int a = 4; a < DEPTH; a++) wr(8'(a), rnd_word());

        clr("R6");
        beat(10'h000, 8'd0, "R5");           // sampled, not yet visible
        idle(2, "R5");                       // 16 appears, then done
        beat(10'h010, 8'd0, "R2");           // e=1 -> 32
        beat(10'h0E8, 8'd0, "R2");           // e=-2, f=8 -> 6, back to back
        beat(10'h200, 8'd0, "R1");           // negative input
        idle(2, "R7");
        beat(10'h000, 8'd3, "R4");           // weight zero flag
        beat(10'h17F, 8'd1, "R4");           // input zero flag
        idle(3, "R9");

        for (int i = 0; i < 10; i++) beat(10'h07F, 8'd1, "R3");
        idle(2, "R3");                       // positive saturation
        for (int i = 0; i < 20; i++) beat(10'h07F, 8'd2, "R3");
        idle(2, "R3");                       // negative saturation
        beat(10'h000, 8'd0, "R3");
        idle(2, "R3");

        beat(10'h07F, 8'd1, "R6");           // in flight when cleared
        clr("R6");
        idle(2, "R6");
        in_valid = 1'b1; in_data = 10'h000; in_waddr = 8'd0;
        clr("R6");                           // same-cycle beat dropped
        in_valid = 1'b0;
        idle(2, "R6");

        wr(8'd0, 10'h020);                   // rewrite: now +4.0
        beat(10'h000, 8'd0, "R8");
        idle(2, "R8");

        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 16);
            if (r == 0) begin
                clr("R6");
            end else if (r == 1) begin
                idle(1, "R9");
                wr(8'($urandom), rnd_word());
            end else if (r < 5) begin
                idle(1, "R9");
            end else begin
                beat(rnd_word(), 8'($urandom), "R2");
            end
        end
        idle(3, "R7");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule